// File: doc/BRIEF.md
# Audio Serial Clock Master

This block produces the bit clock and the left/right frame clock for an audio serial link on which it is the clock master. A single counter, clocked by the master clock, is tapped to give both clocks. A two-bit ratio code sets how many master-clock cycles make up one sample period. A one-bit rate select sets how many bit-clock periods make up one frame. A separate output carries a gated copy of the master clock.

Three power bits bring the block up: one for the left converter, one for the right converter and one for the playback converter. While any of them is set the block runs. When all three are clear it sits idle with its serial clocks held low. The ratio code and rate select are captured only at power-up, so the divide ratio cannot change under a running link.

The control is a three-state machine:
- `ST_OFF`: powered down, configuration being sampled.
- `ST_RUN`: clocks generated.
- `ST_FAULT`: a reserved ratio code was seen at power-up.

Its transitions are:
- OFF to RUN: any power bit set and the ratio code valid.
- OFF to FAULT: any power bit set and ratio code 3.
- RUN to OFF: all power bits clear.
- FAULT to OFF: all power bits clear.

Top module: `aud_clk_master`

## Requirements
- R1: Ratio code 0, 1 or 2, captured at power-up, gives a frame period of 256, 512 or 1024 master-clock cycles.
- R2: Rate select 0, captured at power-up, gives 64 bit-clock periods per frame. Rate select 1 gives 32. In both cases the bit clock has 50% duty.
- R3: `mclk_out` is low while `mclk_out_en` is 0 and follows `mclk_in` while it is 1. A change of the enable made while `mclk_in` is high takes effect only after `mclk_in` next falls, so no partial pulse appears.
- R4: The block runs when any of `pwr_adc_l`, `pwr_adc_r` or `pwr_dac` is 1. It leaves the running state only when all three are 0.
- R5: One master-clock rising edge after all power bits are 0, `bclk` and `fclk` are both low and stay low.
- R6: Changes of `ratio_sel` or `bclk_sel` while powered up do not alter the running bit-clock or frame-clock timing.
- R7: Ratio code 3 at power-up enters the fault state. `cfg_err` goes high on the next edge and `bclk`/`fclk` stay low. `cfg_err` stays high through power-down and clears on the first edge at which the block is powered down with a ratio code other than 3.
- R8: `fclk` is low for the first half of each frame (left channel) and high for the second half (right channel). It changes only in the cycle in which `bclk` falls.
- R9: In the first cycle after power-up both clocks are low and the counter restarts from zero. The first bit-clock and frame-clock phases are therefore full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_in | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_adc_l | input | 1 | Left converter power bit |
| pwr_adc_r | input | 1 | Right converter power bit |
| pwr_dac | input | 1 | Playback converter power bit |
| ratio_sel | input | 2 | Master-to-sample ratio code (0:256, 1:512, 2:1024, 3 reserved) |
| bclk_sel | input | 1 | Bit clocks per frame (0:64, 1:32) |
| mclk_out_en | input | 1 | Enable for the master clock copy |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame (left/right) clock |
| mclk_out | output | 1 | Gated master clock copy |
| cfg_err | output | 1 | Reserved ratio code seen at power-up |

## Verification
A power-down and a change of the ratio code or rate select can land on the same master-clock edge. The bench provokes this by dropping the power bits and writing a new random ratio and rate select at the same falling edge. It then judges that both serial clocks are low one edge later. On the next power-up, the timing must follow the new settings, with a counter restarted from zero. The settings written mid-run in the earlier frames must have had no effect on the cycle-by-cycle model.

// File: rtl/aud_clk_pkg.sv
`timescale 1ns/1ps
package aud_clk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } clk_state_e;

    localparam logic [1:0] RATIO_BAD = 2'd3;
    localparam int NUM_RATIO = 3;

endpackage

// File: rtl/aud_clk_fsm.sv
`timescale 1ns/1ps
module aud_clk_fsm
    import aud_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_on,
    input  logic [1:0] ratio_sel,
    input  logic       bclk_sel,
    output logic       run,
    output logic       err,
    output logic [1:0] ratio_lat,
    output logic       bsel_lat
);

    clk_state_e state_q, state_nxt;
    logic       err_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (pwr_on) begin
                    state_nxt = (ratio_sel == RATIO_BAD) ? ST_FAULT : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!pwr_on) begin
                    state_nxt = ST_OFF;
                end
            end
            ST_FAULT: begin
                if (!pwr_on) begin
                    state_nxt = ST_OFF;
                end
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    // configuration capture and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_lat <= '0;
            bsel_lat  <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == ST_OFF) begin
                ratio_lat <= ratio_sel;
                bsel_lat  <= bclk_sel;
            end
            if (state_nxt == ST_FAULT) begin
                err_q <= 1'b1;
            end else if (state_q == ST_OFF && ratio_sel != RATIO_BAD) begin
                err_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        run = (state_q == ST_RUN);
        err = err_q;
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (!run || ($stable(ratio_lat) && $stable(bsel_lat))));

    // R7
    fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && pwr_on && ratio_sel == RATIO_BAD) |=> (err && !run));

    // R4
    pwr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && pwr_on && ratio_sel != RATIO_BAD) |=> run);

endmodule

// File: rtl/aud_clk_div.sv
`timescale 1ns/1ps
module aud_clk_div
    import aud_clk_pkg::*;
#(
    parameter int BASE_LOG2 = 8,
    parameter int FAST_LOG2 = 6,
    parameter int SLOW_LOG2 = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] ratio_lat,
    input  logic       bsel_lat,
    output logic       bclk,
    output logic       fclk
);

    localparam int CNT_W = BASE_LOG2 + NUM_RATIO - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       tap_f, tap_fast, tap_slow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    for (genvar g = 0; g < 4; g++) begin : g_tap
        if (g < NUM_RATIO) begin : g_valid
            assign tap_f[g]    = cnt_q[BASE_LOG2 - 1 + g];
            assign tap_fast[g] = cnt_q[BASE_LOG2 - 1 + g - FAST_LOG2];
            assign tap_slow[g] = cnt_q[BASE_LOG2 - 1 + g - SLOW_LOG2];
        end else begin : g_rsvd
            assign tap_f[g]    = 1'b0;
            assign tap_fast[g] = 1'b0;
            assign tap_slow[g] = 1'b0;
        end
    end

    always_comb begin
        bclk = run & (bsel_lat ? tap_slow[ratio_lat] : tap_fast[ratio_lat]);
        fclk = run & tap_f[ratio_lat];
    end

    // R8
    fclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(fclk)) |-> $fell(bclk));

    // R9
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt_q == '0 && !bclk && !fclk));

endmodule

// File: rtl/aud_mclk_gate.sv
`timescale 1ns/1ps
module aud_mclk_gate (
    input  logic clk_in,
    input  logic en,
    output logic clk_out
);

    logic gate_q;

    always_latch begin
        if (!clk_in) begin
            gate_q = en;
        end
    end

    assign clk_out = clk_in & gate_q;

endmodule

// File: rtl/aud_clk_master.sv
`timescale 1ns/1ps
module aud_clk_master
    import aud_clk_pkg::*;
#(
    parameter int BASE_LOG2 = 8,
    parameter int FAST_LOG2 = 6,
    parameter int SLOW_LOG2 = 5
) (
    input  logic       mclk_in,
    input  logic       rst_n,
    input  logic       pwr_adc_l,
    input  logic       pwr_adc_r,
    input  logic       pwr_dac,
    input  logic [1:0] ratio_sel,
    input  logic       bclk_sel,
    input  logic       mclk_out_en,
    output logic       bclk,
    output logic       fclk,
    output logic       mclk_out,
    output logic       cfg_err
);

    logic       pwr_on;
    logic       run;
    logic [1:0] ratio_lat;
    logic       bsel_lat;

    assign pwr_on = pwr_adc_l | pwr_adc_r | pwr_dac;

    aud_clk_fsm i_fsm (
        .clk       (mclk_in),
        .rst_n     (rst_n),
        .pwr_on    (pwr_on),
        .ratio_sel (ratio_sel),
        .bclk_sel  (bclk_sel),
        .run       (run),
        .err       (cfg_err),
        .ratio_lat (ratio_lat),
        .bsel_lat  (bsel_lat)
    );

    aud_clk_div #(
        .BASE_LOG2 (BASE_LOG2),
        .FAST_LOG2 (FAST_LOG2),
        .SLOW_LOG2 (SLOW_LOG2)
    ) i_div (
        .clk       (mclk_in),
        .rst_n     (rst_n),
        .run       (run),
        .ratio_lat (ratio_lat),
        .bsel_lat  (bsel_lat),
        .bclk      (bclk),
        .fclk      (fclk)
    );

    aud_mclk_gate i_gate (
        .clk_in  (mclk_in),
        .en      (mclk_out_en),
        .clk_out (mclk_out)
    );

    // R5
    off_low_chk: assert property (@(posedge mclk_in) disable iff (!rst_n)
        !pwr_on |=> (!bclk && !fclk));

endmodule

// File: tb/test_aud_clk_master.sv
`timescale 1ns/1ps
module test_aud_clk_master;

    logic       mclk_in = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_l = 1'b0, pwr_r = 1'b0, pwr_d = 1'b0;
    logic [1:0] ratio_sel = 2'd0;
    logic       bclk_sel = 1'b0;
    logic       mco_en = 1'b0;
    logic       bclk, fclk, mclk_out, cfg_err;

    int checks = 0;
    int failures = 0;

    aud_clk_master i_aud_clk_master (
        .mclk_in     (mclk_in),
        .rst_n       (rst_n),
        .pwr_adc_l   (pwr_l),
        .pwr_adc_r   (pwr_r),
        .pwr_dac     (pwr_d),
        .ratio_sel   (ratio_sel),
        .bclk_sel    (bclk_sel),
        .mclk_out_en (mco_en),
        .bclk        (bclk),
        .fclk        (fclk),
        .mclk_out    (mclk_out),
        .cfg_err     (cfg_err)
    );

    always #5 mclk_in = ~mclk_in;

    initial begin
        #2000000;
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at %0t: act=%b exp=%b", req, $time, act, exp);
        end
    endtask

    function automatic logic exp_bclk(int n, int r, int b);
        int per = (256 << r) / (b ? 32 : 64);
        return ((n / (per / 2)) % 2) == 1;
    endfunction

    function automatic logic exp_fclk(int n, int r);
        int frame = 256 << r;
        return ((n / (frame / 2)) % 2) == 1;
    endfunction

    // power up with (r,b), follow ncyc cycles against the model, power down
    task automatic run_cfg(int r, int b, logic [2:0] pw, int ncyc, bit disturb);
        @(negedge mclk_in);
        ratio_sel = 2'(r);
        bclk_sel  = 1'(b);
        {pwr_l, pwr_r, pwr_d} = pw;
        for (int n = 0; n < ncyc; n++) begin
            @(posedge mclk_in);
            @(negedge mclk_in);
            // R1 R2 R9: bit clock timing from the restart
            chk("R2 bclk", bclk, exp_bclk(n, r, b));
            // R1 R8: frame clock, left half low
            chk("R8 fclk", fclk, exp_fclk(n, r));
            if (n == 0) chk("R4 cfg_err low in run", cfg_err, 1'b0);
            if (disturb && (n % 97) == 50) begin
                // R6: ignored while running
                ratio_sel = 2'($urandom_range(3, 0));
                bclk_sel  = ~bclk_sel;
            end
        end
        {pwr_l, pwr_r, pwr_d} = 3'b000;
        // same-cycle ratio change with power-down
        ratio_sel = 2'($urandom_range(2, 0));
        bclk_sel  = 1'($urandom_range(1, 0));
        @(posedge mclk_in);
        @(negedge mclk_in);
        chk("R5 bclk off", bclk, 1'b0);
        chk("R5 fclk off", fclk, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge mclk_in);
        chk("R5 reset bclk", bclk, 1'b0);
        chk("R5 reset fclk", fclk, 1'b0);
        chk("R7 reset cfg_err", cfg_err, 1'b0);
        chk("R3 reset mclk_out", mclk_out, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge mclk_in);
        chk("R4 idle bclk", bclk, 1'b0);

        // directed: each power bit alone, every ratio code, both rates
        run_cfg(0, 0, 3'b100, 2 * 256 + 7, 1'b0);
        run_cfg(1, 1, 3'b010, 2 * 512 + 7, 1'b0);
        run_cfg(2, 0, 3'b001, 2 * 1024 + 7, 1'b0);
        run_cfg(0, 1, 3'b011, 2 * 256 + 3, 1'b1);
        run_cfg(2, 1, 3'b111, 1024 + 600, 1'b1);

        // random configurations with mid-run disturbance
        for (int k = 0; k < 10; k++) begin
            int r = $urandom_range(2, 0);
            int b = $urandom_range(1, 0);
            logic [2:0] pw = 3'($urandom_range(7, 1));
            run_cfg(r, b, pw, (256 << r) + $urandom_range(300, 0), 1'b1);
        end

        // R7: reserved ratio code
        @(negedge mclk_in);
        ratio_sel = 2'd3;
        pwr_r = 1'b1;
        @(posedge mclk_in);
        @(negedge mclk_in);
        chk("R7 cfg_err set", cfg_err, 1'b1);
        for (int n = 0; n < 60; n++) begin
            @(posedge mclk_in);
            @(negedge mclk_in);
            chk("R7 bclk low in fault", bclk, 1'b0);
            chk("R7 fclk low in fault", fclk, 1'b0);
            if (n == 10) ratio_sel = 2'd1;
        end
        chk("R7 cfg_err held while powered", cfg_err, 1'b1);
        ratio_sel = 2'd3;
        pwr_r = 1'b0;
        repeat (5) @(negedge mclk_in);
        chk("R7 cfg_err held in power-down", cfg_err, 1'b1);
        ratio_sel = 2'd0;
        @(posedge mclk_in);
        @(negedge mclk_in);
        chk("R7 cfg_err cleared", cfg_err, 1'b0);
        run_cfg(0, 0, 3'b100, 300, 1'b0);

        // R3: gated master clock copy
        @(negedge mclk_in);
        mco_en = 1'b1;
        @(posedge mclk_in); #2;
        chk("R3 mclk_out high", mclk_out, 1'b1);
        @(negedge mclk_in); #1;
        chk("R3 mclk_out low phase", mclk_out, 1'b0);
        @(posedge mclk_in); #1;
        mco_en = 1'b0;
        #2;
        chk("R3 disable held to fall", mclk_out, 1'b1);
        @(negedge mclk_in); #1;
        chk("R3 low after disable", mclk_out, 1'b0);
        @(posedge mclk_in); #2;
        chk("R3 gated off", mclk_out, 1'b0);
        #1;
        mco_en = 1'b1;
        #1;
        chk("R3 enable waits for fall", mclk_out, 1'b0);
        @(posedge mclk_in); #2;
        chk("R3 enabled again", mclk_out, 1'b1);
        for (int k = 0; k < 20; k++) begin
            logic e;
            @(negedge mclk_in); #1;
            e = 1'($urandom_range(1, 0));
            mco_en = e;
            @(posedge mclk_in); #2;
            chk("R3 random enable", mclk_out, e);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule